// File: doc/BRIEF.md
# SPI Flash User-Mode Byte Engine

This block is the chip-select side of a serial flash master when it is driven directly by the CPU. Software programs a 32-bit control word that holds a two-bit mode field, a stop bit and two data-width bits. Once the mode field says user and the stop bit is cleared, chip select goes low and stays low until software sets the stop bit again. While chip select is low, each access to the memory window moves one byte on the serial bus. A window write sends the byte. A window read clocks in a byte and returns it, sending zeros meanwhile.

Software sends opcode, address and dummy bytes one at a time with the data width left at one line. Address bytes go most significant first, and dummy cycles are all-zero bytes. Before the data bytes, software may rewrite the control word to widen the bus to two or four lines while chip select stays low. The engine runs the serial clock in mode 0. The clock idles low, data changes on the falling edge and is sampled on the rising edge. A window access holds off its ready handshake until the whole byte has shifted.

Top module: `spi_user_engine`

## Requirements
- R1: After reset the control word reads 0x0000_0004, which is the normal-read mode (mode field 0) with the stop bit set. `spi_cs_n` is 1, `spi_sck` is 0 and all four output enables are 0.
- R2: `spi_cs_n` is 0 only when control bits [1:0] equal 2'b11 (user) and control bit 2 (stop) is 0. The values 1 (command read) and 2 (command write) keep chip select high.
- R3: On a single-line window write, the byte leaves on `spi_io_out[0]`, MSB first, over exactly 8 rising edges of `spi_sck`. Each bit is stable at its rising edge, and `spi_sck` idles at 0.
- R4: On a single-line window read, `spi_io_in[1]` is sampled on 8 rising edges, MSB first, and the result is returned on `win_rdata`. `spi_io_out[0]` carries zeros throughout.
- R5: Control bit 29 selects two data lines and control bit 30 selects four; bit 30 wins when both are set. A byte then takes 4 or 2 rising edges. Bits travel on `spi_io[1:0]` or `spi_io[3:0]`, with the highest pair or nibble first.
- R6: During a two- or four-line window read, all four output enables are 0, so the lines are released.
- R7: Each window access completes with `win_ready` high for exactly one cycle, after the last bit has shifted. At that point `spi_sck` is already back at 0.
- R8: A window access made while chip select is high completes without any `spi_sck` edge and returns 0. This covers a mode other than user, or user mode with the stop bit set.
- R9: Rewriting the control word to change only the data width keeps `spi_cs_n` low. Following bytes use the new width.
- R10: Writing the control word with the stop bit set ends the transfer and drives `spi_cs_n` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | New control word |
| cfg_rdata | output | 32 | Current control word |
| win_valid | input | 1 | Window access request, held until `win_ready` |
| win_write | input | 1 | 1 = window write, 0 = window read |
| win_wdata | input | DW | Byte to send on a window write |
| win_ready | output | 1 | One-cycle completion of a window access |
| win_rdata | output | DW | Byte received, valid with `win_ready` |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_io_out | output | 4 | Serial data out per line |
| spi_io_oe | output | 4 | Output enable per line |
| spi_io_in | input | 4 | Serial data in per line |

## Verification
The bench builds the engine with DW = 8 and HALF_CYC = 1, so each serial half-period is one system cycle. With this setting, every byte of a full opcode, dual-data and quad-data sequence finishes within a few dozen cycles. A bench-side flash model counts rising edges and collects the bits on the lines selected for each vector. It also drives its own byte back in, which makes edge counts, bit order and line release directly visible at the pins.

// File: rtl/spi_ue_pkg.sv
// Shared definitions for the user-mode serial flash engine.
// Assumes a 32-bit control word; bit positions are fixed by software.
package spi_ue_pkg;
    typedef enum logic [1:0] {
        LN_ONE  = 2'd0,
        LN_TWO  = 2'd1,
        LN_FOUR = 2'd2
    } lanes_t;

    localparam int          MODE_LSB   = 0;
    localparam int          STOP_BIT   = 2;
    localparam int          DUAL_BIT   = 29;
    localparam int          QUAD_BIT   = 30;
    localparam logic [1:0]  MODE_USER  = 2'b11;
    localparam logic [31:0] CTRL_RESET = 32'h0000_0004;
endpackage

// File: rtl/spi_ue_ctrl.sv
// Control word holder. Decodes chip-select enable and data-phase width.
// Assumes software rewrites the word only between window accesses.
module spi_ue_ctrl
    import spi_ue_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] ctrl_q,
    output logic        xfer_en,
    output lanes_t      lanes
);
    // Hold the control word; reset to normal read with stop set.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl_q <= CTRL_RESET;
        else if (wr_en) ctrl_q <= wdata;
    end

    // Chip select is active only in user mode with stop cleared.
    assign xfer_en = (ctrl_q[MODE_LSB+1:MODE_LSB] == MODE_USER) && !ctrl_q[STOP_BIT];

    // Four lines take precedence over two.
    always_comb begin
        if (ctrl_q[QUAD_BIT])      lanes = LN_FOUR;
        else if (ctrl_q[DUAL_BIT]) lanes = LN_TWO;
        else                       lanes = LN_ONE;
    end

    p_reset_value_r1: assert property (@(posedge clk)
        !rst_n |=> (ctrl_q == CTRL_RESET));
endmodule

// File: rtl/spi_ue_shifter.sv
// Byte serializer/deserializer for serial clock mode 0.
// One window access moves one DW-bit byte over DW/lanes clock periods.
// Each half period of the serial clock lasts HALF_CYC system cycles.
// Assumes the requester holds req_valid until ready and drops it after.
module spi_ue_shifter
    import spi_ue_pkg::*;
#(
    parameter int DW       = 8,
    parameter int HALF_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  lanes_t        lanes,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [DW-1:0] req_data,
    output logic          ready,
    output logic [DW-1:0] rdata,
    output logic          sck,
    output logic [3:0]    tx_bits,
    input  logic [3:0]    rx_in,
    output lanes_t        cur_lanes,
    output logic          rd_dir
);
    localparam int CW  = $clog2(DW);
    localparam int DVW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [DVW-1:0] DIV_LOAD = DVW'(HALF_CYC - 1);

    typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_DONE} st_t;

    st_t            state;
    logic [DVW-1:0] div;
    logic [CW-1:0]  beat;
    logic [DW-1:0]  sh;
    logic [DW-1:0]  rx;

    // Index of the last beat for a given data width.
    function automatic logic [CW-1:0] last_beat(input lanes_t l);
        case (l)
            LN_ONE:  return CW'(DW - 1);
            LN_TWO:  return CW'(DW / 2 - 1);
            default: return CW'(DW / 4 - 1);
        endcase
    endfunction

    // Sequence one byte: low half, high half (sample), repeat per beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            div       <= '0;
            beat      <= '0;
            sh        <= '0;
            rx        <= '0;
            cur_lanes <= LN_ONE;
            rd_dir    <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    if (en) begin
                        sh        <= req_write ? req_data : '0;
                        rd_dir    <= !req_write;
                        cur_lanes <= lanes;
                        beat      <= last_beat(lanes);
                        div       <= DIV_LOAD;
                        state     <= S_LO;
                    end else begin
                        rx    <= '0;
                        state <= S_DONE;
                    end
                end
                S_LO: if (div == '0) begin
                    div   <= DIV_LOAD;
                    state <= S_HI;
                    case (cur_lanes)
                        LN_ONE:  rx <= {rx[DW-2:0], rx_in[1]};
                        LN_TWO:  rx <= {rx[DW-3:0], rx_in[1:0]};
                        default: rx <= {rx[DW-5:0], rx_in};
                    endcase
                end else begin
                    div <= div - 1'b1;
                end
                S_HI: if (div == '0) begin
                    div <= DIV_LOAD;
                    if (beat == '0) begin
                        state <= S_DONE;
                    end else begin
                        beat  <= beat - 1'b1;
                        state <= S_LO;
                        case (cur_lanes)
                            LN_ONE:  sh <= {sh[DW-2:0], 1'b0};
                            LN_TWO:  sh <= {sh[DW-3:0], 2'b0};
                            default: sh <= {sh[DW-5:0], 4'b0};
                        endcase
                    end
                end else begin
                    div <= div - 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Outputs derived from the sequencer state.
    assign sck   = (state == S_HI);
    assign ready = (state == S_DONE);
    assign rdata = rx;

    // Present the leading bit, pair or nibble of the shift register.
    always_comb begin
        case (cur_lanes)
            LN_ONE:  tx_bits = {3'b000, sh[DW-1]};
            LN_TWO:  tx_bits = {2'b00, sh[DW-1:DW-2]};
            default: tx_bits = sh[DW-1:DW-4];
        endcase
    end

    p_beat_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LO || state == S_HI) |-> (beat <= last_beat(cur_lanes)));
    p_hold_while_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HI && $past(state == S_HI)) |-> $stable(sh));
    p_ignore_no_clock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && req_valid && !en) |=> (state == S_DONE));
endmodule

// File: rtl/spi_ue_pad.sv
// Per-line output value and enable for the four serial data lines.
// Line 0 is driven for single-line work, and lines are released in wide reads.
module spi_ue_pad
    import spi_ue_pkg::*;
(
    input  logic       active,
    input  lanes_t     lanes,
    input  logic       rd_dir,
    input  logic [3:0] tx_bits,
    output logic [3:0] io_out,
    output logic [3:0] io_oe
);
    // Select which lines the engine drives.
    always_comb begin
        if (!active) begin
            io_oe = 4'b0000;
        end else begin
            case (lanes)
                LN_ONE:  io_oe = 4'b0001;
                LN_TWO:  io_oe = rd_dir ? 4'b0000 : 4'b0011;
                default: io_oe = rd_dir ? 4'b0000 : 4'b1111;
            endcase
        end
    end

    // Output value is zero on released lines.
    assign io_out = tx_bits & io_oe;
endmodule

// File: rtl/spi_user_engine.sv
// User-mode serial flash engine for one chip select.
// The control word gates chip select and picks the data width. Each
// window access moves one byte and holds off win_ready until it has shifted.
// Assumes the control word is not rewritten while a byte is in flight.
module spi_user_engine
    import spi_ue_pkg::*;
#(
    parameter int DW       = 8,
    parameter int HALF_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    input  logic          win_valid,
    input  logic          win_write,
    input  logic [DW-1:0] win_wdata,
    output logic          win_ready,
    output logic [DW-1:0] win_rdata,
    output logic          spi_sck,
    output logic          spi_cs_n,
    output logic [3:0]    spi_io_out,
    output logic [3:0]    spi_io_oe,
    input  logic [3:0]    spi_io_in
);
    logic       xfer_en;
    lanes_t     cfg_lanes;
    lanes_t     cur_lanes;
    logic       rd_dir;
    logic [3:0] tx_bits;

    spi_ue_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wdata   (cfg_wdata),
        .ctrl_q  (cfg_rdata),
        .xfer_en (xfer_en),
        .lanes   (cfg_lanes)
    );

    spi_ue_shifter #(.DW(DW), .HALF_CYC(HALF_CYC)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (xfer_en),
        .lanes     (cfg_lanes),
        .req_valid (win_valid),
        .req_write (win_write),
        .req_data  (win_wdata),
        .ready     (win_ready),
        .rdata     (win_rdata),
        .sck       (spi_sck),
        .tx_bits   (tx_bits),
        .rx_in     (spi_io_in),
        .cur_lanes (cur_lanes),
        .rd_dir    (rd_dir)
    );

    spi_ue_pad u_pad (
        .active  (xfer_en),
        .lanes   (cur_lanes),
        .rd_dir  (rd_dir),
        .tx_bits (tx_bits),
        .io_out  (spi_io_out),
        .io_oe   (spi_io_oe)
    );

    // Chip select follows the decoded control word.
    assign spi_cs_n = !xfer_en;

    p_sck_only_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> !spi_cs_n);
    p_ready_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        win_ready |=> !win_ready);
    p_ready_sck_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        win_ready |-> !spi_sck);
    p_wide_read_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && rd_dir && cur_lanes != LN_ONE) |-> (spi_io_oe == 4'b0000));
endmodule

// File: tb/spi_user_engine_bench.sv
module spi_user_engine_bench;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          win_valid = 1'b0;
    logic          win_write = 1'b0;
    logic [DW-1:0] win_wdata = '0;
    logic          win_ready;
    logic [DW-1:0] win_rdata;
    logic          spi_sck, spi_cs_n;
    logic [3:0]    spi_io_out, spi_io_oe, spi_io_in;

    int checks = 0;
    int errors = 0;

    spi_user_engine #(.DW(DW), .HALF_CYC(1)) u_spi_user_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .win_valid(win_valid), .win_write(win_write),
        .win_wdata(win_wdata), .win_ready(win_ready), .win_rdata(win_rdata),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_io_out(spi_io_out),
        .spi_io_oe(spi_io_oe), .spi_io_in(spi_io_in)
    );

    always #2 clk = ~clk;

    // Flash model state
    int         bl = 1;
    logic       brd = 1'b0;
    logic [7:0] slave_byte = '0;
    int         slave_beat = 0;
    int         edge_cnt = 0;
    logic [7:0] cap = '0;
    logic       oe_bad = 1'b0;
    logic [7:0] got_rdata;
    logic       sck_at_done, ready_after;

    always @(posedge spi_sck) begin
        edge_cnt = edge_cnt + 1;
        if (bl == 1)      cap = {cap[6:0], spi_io_out[0]};
        else if (bl == 2) cap = {cap[5:0], spi_io_out[1:0]};
        else              cap = {cap[3:0], spi_io_out[3:0]};
        if (brd && bl != 1 && spi_io_oe != 4'b0000) oe_bad = 1'b1;
    end

    always @(negedge spi_sck) slave_beat = slave_beat + 1;

    always_comb begin
        spi_io_in = 4'b0000;
        if (bl == 1 && slave_beat < 8)
            spi_io_in[1] = slave_byte[7 - slave_beat];
        else if (bl == 2 && slave_beat < 4)
            spi_io_in[1:0] = slave_byte[7 - 2*slave_beat -: 2];
        else if (bl == 4 && slave_beat < 2)
            spi_io_in[3:0] = slave_byte[7 - 4*slave_beat -: 4];
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [31:0] v);
        cfg_wdata = v;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic xfer(input logic wr, input logic [7:0] tx, input logic [7:0] sl, input int lanes);
        bl = lanes; brd = !wr; slave_byte = sl; slave_beat = 0;
        edge_cnt = 0; cap = '0; oe_bad = 1'b0;
        win_write = wr; win_wdata = tx; win_valid = 1'b1;
        do @(negedge clk); while (!win_ready);
        got_rdata = win_rdata;
        sck_at_done = spi_sck;
        win_valid = 1'b0;
        @(negedge clk);
        ready_after = win_ready;
    endtask

    function automatic logic [31:0] ctrl_for(input int lanes);
        return 32'h3 | ((lanes == 2) ? 32'h2000_0000 : 32'h0) | ((lanes == 4) ? 32'h4000_0000 : 32'h0);
    endfunction

    // {lanes(1,2,4) in 3 bits, write, tx byte, slave byte}
    localparam logic [19:0] VEC [8] = '{
        {3'd1, 1'b1, 8'hA5, 8'h00},
        {3'd1, 1'b1, 8'h3C, 8'hFF},
        {3'd1, 1'b0, 8'h00, 8'h96},
        {3'd1, 1'b0, 8'h00, 8'hC3},
        {3'd2, 1'b1, 8'hB4, 8'h00},
        {3'd2, 1'b0, 8'h00, 8'h5A},
        {3'd4, 1'b1, 8'hE7, 8'h00},
        {3'd4, 1'b0, 8'h00, 8'h1F}
    };

    initial begin
        #(4 * 20000);
        errors++;
        $display("FAIL watchdog R7 actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cfg_rdata == 32'h4, "R1 ctrl", cfg_rdata, 32'h4);
        chk(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
        chk(spi_sck == 1'b0, "R1 sck", spi_sck, 0);
        chk(spi_io_oe == 4'b0, "R1 oe", spi_io_oe, 0);

        // Table walk
        foreach (VEC[i]) begin
            int         ln = int'(VEC[i][19:17]);
            logic       w  = VEC[i][16];
            logic [7:0] t  = VEC[i][15:8];
            logic [7:0] s  = VEC[i][7:0];
            cfg(ctrl_for(ln));
            xfer(w, t, s, ln);
            chk(edge_cnt == 8 / ln, "R3/R5 edges", edge_cnt, 8 / ln);
            chk(!sck_at_done && !ready_after, "R7 ready", {sck_at_done, ready_after}, 0);
            if (w) begin
                chk(cap == t, "R3/R5 tx bits", cap, t);
            end else begin
                chk(got_rdata == s, "R4/R5 rx byte", got_rdata, s);
                if (ln == 1) chk(cap == 8'h00, "R4 io0 zero", cap, 0);
                else         chk(!oe_bad, "R6 lines released", oe_bad, 0);
            end
        end

        // R2 mode decode
        cfg(32'h1);
        chk(spi_cs_n == 1'b1, "R2 cmd read mode", spi_cs_n, 1);
        cfg(32'h2);
        chk(spi_cs_n == 1'b1, "R2 cmd write mode", spi_cs_n, 1);
        // R8 ignored access outside user mode
        xfer(1'b1, 8'hFF, 8'hAA, 1);
        chk(edge_cnt == 0 && got_rdata == 8'h00, "R8 non-user", edge_cnt, 0);
        cfg(32'h3);
        chk(spi_cs_n == 1'b0, "R2 user active", spi_cs_n, 0);

        // R9 opcode single, then widen mid-transfer
        xfer(1'b1, 8'h3B, 8'h00, 1);
        chk(cap == 8'h3B, "R9 opcode", cap, 8'h3B);
        cfg(32'h2000_0003);
        chk(spi_cs_n == 1'b0, "R9 cs held", spi_cs_n, 0);
        xfer(1'b0, 8'h00, 8'hD2, 2);
        chk(got_rdata == 8'hD2 && edge_cnt == 4, "R9 dual after widen", got_rdata, 8'hD2);
        // R5 quad wins over dual
        cfg(32'h6000_0003);
        xfer(1'b1, 8'h69, 8'h00, 4);
        chk(edge_cnt == 2 && cap == 8'h69, "R5 quad precedence", edge_cnt, 2);

        // R10 stop ends transfer, R8 access with stop set
        cfg(32'h7);
        chk(spi_cs_n == 1'b1, "R10 stop", spi_cs_n, 1);
        xfer(1'b0, 8'h00, 8'h77, 1);
        chk(edge_cnt == 0 && got_rdata == 8'h00, "R8 stopped", got_rdata, 0);
        chk(spi_io_oe == 4'b0, "R10 oe idle", spi_io_oe, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule